// File: doc/BRIEF.md
# Predicated Vector Signed-Divide Shifter

This block divides every selected element of a packed vector by a power of two, treating each element as a signed integer and rounding the quotient toward zero, the way integer division does. A single 7-bit immediate encodes both the element width (8, 16, 32 or 64 bits) and the shift distance. A per-byte predicate chooses which elements are processed. Elements that are not selected come back with their original contents. The result is meant to be written back over the source register.

The datapath is fully parallel. Every element of the chosen width is computed in the same cycle. The output vector and an illegal-encoding flag are registered and appear one clock after an input is accepted. Between accepted inputs the outputs hold their last values.

Top module: `vds_shifter`

## Requirements
- R1: The element width comes from the highest set bit of size field `shift_imm[6:3]`: pattern 1xxx gives 64 bits, 01xx gives 32, 001x gives 16, and 0001 gives 8.
- R2: The shift distance is twice the element width minus the unsigned value of all seven `shift_imm` bits.
- R3: For every legal immediate, the shift distance lies between 1 and the element width, inclusive. A shift equal to the full width is supported.
- R4: An active element becomes its signed value divided by 2^shift, truncated toward zero. For example, -7 shifted by 2 gives -1, and 7 shifted by 2 gives 1. A non-negative element never turns negative, and a negative element never turns positive.
- R5: Element e, which occupies bits [e*W +: W], is active when `byte_pred[e*W/8]` is 1. When that bit is 0, the element is returned unchanged.
- R6: The rounding bias cannot overflow. The most negative value of any width, shifted by the full width, gives 0.
- R7: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and is 0 otherwise.
- R8: A size field of 0000 is illegal. In that case `undef_flag` is set and `dst_vec` equals `src_vec` unchanged. A later legal input clears the flag.
- R9: After synchronous reset (`rst_n` = 0), `out_valid`, `undef_flag` and `dst_vec` are all 0.
- R10: While `in_valid` is 0, `dst_vec` and `undef_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept inputs this cycle |
| shift_imm | input | 7 | Size field [6:3] and low shift bits [2:0] |
| byte_pred | input | VLEN/8 | One predicate bit per byte |
| src_vec | input | VLEN | Source vector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| undef_flag | output | 1 | Last accepted immediate was illegal |
| dst_vec | output | VLEN | Result vector |

## Verification
A wrong element-width decode shows up at once in the next result. Lane boundaries move, so whole groups of bytes come back shifted by the wrong amount or wrongly masked. A missing or narrow bias shows up on negative inputs as results one step too negative. It also shows up as a non-zero value when the most negative element is shifted by the full width. Every result is registered, so any such fault is visible on `dst_vec` exactly one clock after the offending input and stays there until the next accepted input.

// File: rtl/vds_pkg.sv
// Package: shared types and widths for the vector signed-divide shifter.
// Assumes the immediate is always 7 bits and the element widths are 8..64.
package vds_pkg;
    localparam int IMM_W   = 7;
    localparam int SHIFT_W = 7;
    localparam int NUM_ESZ = 4;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esz_t;

    // Element width in bits for a width code.
    function automatic int esz_bits(input esz_t code);
        return 8 << code;
    endfunction
endpackage

// File: rtl/vds_imm_decode.sv
// Module: immediate decoder.
// Splits the 7-bit immediate into an element-width code and a shift
// distance, and flags the all-zero size field as illegal.
// Assumes: purely combinational; outputs are don't-care when illegal.
module vds_imm_decode
    import vds_pkg::*;
(
    input  logic [IMM_W-1:0]   imm,
    output esz_t               esz,
    output logic [SHIFT_W-1:0] shamt,
    output logic               illegal
);
    logic [3:0] size_fld;
    logic [7:0] twice_w;
    logic [7:0] diff;

    assign size_fld = imm[6:3];

    // Priority pick of the highest set size bit.
    always_comb begin
        if (size_fld[3])      esz = ESZ_64;
        else if (size_fld[2]) esz = ESZ_32;
        else if (size_fld[1]) esz = ESZ_16;
        else                  esz = ESZ_8;
    end

    // Shift distance = 2*width - immediate.
    always_comb begin
        twice_w = 8'd16 << esz;
        diff    = twice_w - {1'b0, imm};
        shamt   = diff[SHIFT_W-1:0];
        illegal = (size_fld == 4'd0);
    end

    // Shift range guard for legal encodings.
    always_comb begin
        if (!illegal) begin
            assert_shift_range_R3: assert (shamt >= 7'd1 && int'(shamt) <= esz_bits(esz))
                else $error("shift %0d out of range", shamt);
        end
    end
endmodule

// File: rtl/vds_lane.sv
// Module: one element lane.
// Biases a negative element by (2^shift - 1) one bit wider than the
// element, then shifts right arithmetically, so the quotient truncates
// toward zero. Inactive lanes pass the element through.
// Assumes: shamt may exceed EW when this lane's width is not selected;
// the output is then unused.
module vds_lane #(
    parameter int EW      = 8,
    parameter int SHIFT_W = 7
) (
    input  logic [EW-1:0]      elem_in,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic               active,
    output logic [EW-1:0]      elem_out
);
    logic signed [EW:0] wide;
    logic signed [EW:0] bias;
    logic signed [EW:0] summed;
    logic signed [EW:0] shifted;

    // Widened bias-and-shift datapath.
    always_comb begin
        wide    = signed'({elem_in[EW-1], elem_in});
        bias    = elem_in[EW-1] ? signed'(~({(EW+1){1'b1}} << shamt)) : '0;
        summed  = wide + bias;
        shifted = summed >>> shamt;
        elem_out = active ? shifted[EW-1:0] : elem_in;
    end

    // Active result keeps the sign direction of the input.
    always_comb begin
        if (active) begin
            assert_sign_kept_R4: assert (!(!elem_in[EW-1] && elem_out[EW-1]) &&
                                         !(elem_in[EW-1] && !elem_out[EW-1] && elem_out != '0))
                else $error("sign flipped in lane width %0d", EW);
        end
    end
endmodule

// File: rtl/vds_bank.sv
// Module: bank of lanes for one element width.
// Splits the vector into VLEN/EW elements and gates each with the
// predicate bit of its lowest byte.
// Assumes: VLEN is a multiple of EW and EW a multiple of 8.
module vds_bank #(
    parameter int VLEN    = 128,
    parameter int EW      = 8,
    parameter int SHIFT_W = 7
) (
    input  logic [VLEN-1:0]    vec_in,
    input  logic [VLEN/8-1:0]  pred,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [VLEN-1:0]    vec_out
);
    localparam int NELEM = VLEN / EW;
    localparam int BPE   = EW / 8;

    for (genvar e = 0; e < NELEM; e++) begin : g_lane
        vds_lane #(.EW(EW), .SHIFT_W(SHIFT_W)) u_lane (
            .elem_in  (vec_in[e*EW +: EW]),
            .shamt    (shamt),
            .active   (pred[e*BPE]),
            .elem_out (vec_out[e*EW +: EW])
        );
    end
endmodule

// File: rtl/vds_shifter.sv
// Module: top of the predicated vector signed-divide shifter.
// Decodes the immediate, runs one lane bank per element width in
// parallel, picks the decoded width and registers the result.
// Assumes: synchronous active-low reset; outputs load only on in_valid.
module vds_shifter
    import vds_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [6:0]        shift_imm,
    input  logic [VLEN/8-1:0] byte_pred,
    input  logic [VLEN-1:0]   src_vec,
    output logic              out_valid,
    output logic              undef_flag,
    output logic [VLEN-1:0]   dst_vec
);
    esz_t               esz;
    logic [SHIFT_W-1:0] shamt;
    logic               illegal;
    logic [VLEN-1:0]    bank_out [NUM_ESZ];
    logic [VLEN-1:0]    picked;

    vds_imm_decode u_dec (
        .imm     (shift_imm),
        .esz     (esz),
        .shamt   (shamt),
        .illegal (illegal)
    );

    for (genvar g = 0; g < NUM_ESZ; g++) begin : g_bank
        vds_bank #(.VLEN(VLEN), .EW(8 << g), .SHIFT_W(SHIFT_W)) u_bank (
            .vec_in  (src_vec),
            .pred    (byte_pred),
            .shamt   (shamt),
            .vec_out (bank_out[g])
        );
    end

    // Select the bank of the decoded width; illegal passes the source.
    always_comb begin
        picked = illegal ? src_vec : bank_out[esz];
    end

    // Output registers with valid tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            undef_flag <= 1'b0;
            dst_vec    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                undef_flag <= illegal;
                dst_vec    <= picked;
            end
        end
    end

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_illegal_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_imm[6:3] == 4'd0) |=> (undef_flag && dst_vec == $past(src_vec)));
    assert_inactive_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_imm[6:3] != 4'd0 && !byte_pred[0]) |=> dst_vec[7:0] == $past(src_vec[7:0]));
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_vec) && $stable(undef_flag)));
endmodule

// File: tb/tb_vds_shifter.sv
module tb_vds_shifter;
    localparam int VLEN = 128;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [6:0]   imm;
        logic [15:0]  pred;
        logic [127:0] vec;
    } stim_t;

    localparam int NSTIM = 8;
    localparam stim_t STIM [NSTIM] = '{
        '{7'h0F, 16'hFFFF, 128'h807FFF01FE03FD10F00055AAC33C817E},
        '{7'h0B, 16'hA5A5, 128'h807FFF01FE03FD10F00055AAC33C817E},
        '{7'h1C, 16'h5555, 128'h80007FFFFFFF0001F00D1234C0010FFF},
        '{7'h10, 16'hFFFF, 128'h80007FFFFFFF0001F00D1234C0010FFF},
        '{7'h21, 16'h0F0F, 128'h800000007FFFFFFFFFFFFFFFC0000001},
        '{7'h3F, 16'hFFFF, 128'h800000007FFFFFFFFFFFFFFFC0000001},
        '{7'h7F, 16'h0101, 128'h8000000000000001FFFFFFFFFFFFFFFF},
        '{7'h41, 16'h00FF, 128'h80000000000000008000000000000000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [6:0] shift_imm = '0;
    logic [VLEN/8-1:0] byte_pred = '0;
    logic [VLEN-1:0] src_vec = '0;
    logic out_valid, undef_flag;
    logic [VLEN-1:0] dst_vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    vds_shifter #(.VLEN(VLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .shift_imm(shift_imm),
        .byte_pred(byte_pred), .src_vec(src_vec), .out_valid(out_valid),
        .undef_flag(undef_flag), .dst_vec(dst_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: signed division with truncation, element by element.
    function automatic logic [127:0] model(input logic [6:0] imm, input logic [15:0] pred,
                                           input logic [127:0] v);
        int ts, es, sh;
        logic [127:0] r, raw, msk;
        logic signed [127:0] x, d, q;
        ts = int'(imm[6:3]);
        if (ts == 0) return v;
        es = (ts >= 8) ? 64 : (ts >= 4) ? 32 : (ts >= 2) ? 16 : 8;
        sh = 2 * es - int'(imm);
        msk = (128'd1 << es) - 128'd1;
        r = v;
        for (int e = 0; e < 128 / es; e++) begin
            if (pred[e * es / 8]) begin
                raw = (v >> (e * es)) & msk;
                x = raw[es-1] ? signed'(raw - (128'd1 << es)) : signed'(raw);
                d = 128'sd1 <<< sh;
                q = x / d;
                r = (r & ~(msk << (e * es))) | ((q & msk) << (e * es));
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [6:0] imm, input logic [15:0] pred, input logic [127:0] v);
        @(negedge clk);
        shift_imm = imm; byte_pred = pred; src_vec = v; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 out_valid", 128'(out_valid), 128'd0);
        chk("R9 undef_flag", 128'(undef_flag), 128'd0);
        chk("R9 dst_vec", dst_vec, 128'd0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 against the reference model.
        for (int i = 0; i < NSTIM; i++) begin
            apply(STIM[i].imm, STIM[i].pred, STIM[i].vec);
            chk($sformatf("R1/R2/R3/R4/R5 vec %0d", i), dst_vec,
                model(STIM[i].imm, STIM[i].pred, STIM[i].vec));
            chk($sformatf("R7 valid %0d", i), 128'(out_valid), 128'd1);
        end

        // R4: truncation toward zero, 8-bit shift by 2.
        apply(7'h0E, 16'hFFFF, 128'h07F9);
        chk("R4 -7>>2 and 7>>2", dst_vec, 128'h01FF);
        apply(7'h0F, 16'hFFFF, {16{8'hFF}});
        chk("R4 -1>>1 gives 0", dst_vec, 128'd0);

        // R6: most negative value by full width.
        apply(7'h08, 16'hFFFF, {16{8'h80}});
        chk("R6 byte min by 8", dst_vec, 128'd0);
        apply(7'h40, 16'hFFFF, {2{64'h8000000000000000}});
        chk("R6 dword min by 64", dst_vec, 128'd0);

        // R5: all inactive.
        apply(7'h0F, 16'h0000, 128'hDEADBEEF);
        chk("R5 all inactive", dst_vec, 128'hDEADBEEF);

        // R7/R10: idle cycle keeps outputs, valid drops.
        @(negedge clk);
        chk("R7 idle valid low", 128'(out_valid), 128'd0);
        chk("R10 hold dst", dst_vec, 128'hDEADBEEF);

        // R8: illegal size field.
        apply(7'h05, 16'hFFFF, 128'h80818283);
        chk("R8 undef set", 128'(undef_flag), 128'd1);
        chk("R8 source passthru", dst_vec, 128'h80818283);
        @(negedge clk);
        chk("R10 hold undef", 128'(undef_flag), 128'd1);
        apply(7'h0F, 16'hFFFF, 128'h04);
        chk("R8 undef cleared", 128'(undef_flag), 128'd0);
        chk("R8 legal after illegal", dst_vec, 128'h02);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule